// File: doc/BRIEF.md
# LPC I/O Burst Host

This block lets a processor reach legacy I/O-port peripherals over a low-pin-count bus. Software sets three values in a small 32-bit register file: a cycle count, a command (direction and address mode) and a 16-bit target port. For a write it loads the data bytes into a write FIFO. It then sets the start bit and polls a status register until the engine is idle. For a read it then drains the returned bytes from a read FIFO.

One start runs up to four byte-wide I/O cycles back to back. The cycles target either consecutive ports or one fixed port, which suits a data register that is read or written repeatedly. Each cycle is framed on the pins with a frame strobe and a 4-bit multiplexed address/data bus. The engine tolerates a bounded number of peripheral wait states. On a sync error or a wait timeout it abandons the burst with an abort pattern and reports the error in the status register.

Top module: `lpc_burst_host`

## Requirements
- R1: After reset, status (offset 0x04, bit 0 = idle, bit 1 = finished) reads 0x1, command and count read 0, `lframe_n` is high and `lad_oe` is low.
- R2: Writing bit 0 = 1 to offset 0x00 starts a burst of min(count, 4) cycles, where count sits at offset 0x10. Idle reads 0 from the clock after the start. A count of 0 completes at once with status 0x3 and no frame on the pins.
- R3: Each cycle opens with one clock of `lframe_n` low and nibble 0000. A type nibble follows (0000 read, 0010 write), then the 16-bit port as four nibbles, most significant first.
- R4: With command bit 3 (offset 0x14) set, every cycle uses the programmed port (offset 0x20). With bit 3 clear, cycle i uses port + i, wrapping at 16 bits. Command bit 0 selects the direction: 1 = write, 0 = read.
- R5: Writes to offset 0x24 push bits 7:0 into a 4-entry write FIFO, and a push into a full FIFO is dropped. Write cycles send the bytes in push order, low nibble first, right after the address. An empty FIFO supplies 0xFF. Bytes left over are discarded when the burst ends.
- R6: After the address (and write data) the host drives 1111 for one clock, then releases the bus for one clock, then samples sync. Sync 0000 means ready. 0101 and 0110 are wait states, and up to 256 of them per cycle are accepted.
- R7: On a read, the two nibbles after a ready sync (low first) form a byte that enters the read FIFO in cycle order. Reads of offset 0x28 pop it into bits 7:0. An empty read FIFO returns 0xFF, and the read FIFO is emptied when a burst starts.
- R8: A sync code other than 0000/0101/0110, or a 257th wait state in one cycle, ends the burst. `lframe_n` is held low with 1111 driven for 4 clocks, and status then reads 0x1.
- R9: A burst whose cycles all complete ends with status 0x3 once the last cycle's two closing turnaround clocks have passed.
- R10: While a burst runs, writes to start, count, command, address and the write FIFO are ignored.
- R11: A cycle with w wait states keeps the engine busy for 13 + w clocks, so an n-cycle burst reads busy for n × (13 + w) status polls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the LPC bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wen | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_ren | input | 1 | Register read strobe (pops the read FIFO at 0x28) |
| bus_rdata | output | 32 | Register read data, valid in the strobe cycle |
| lframe_n | output | 1 | Active-low frame strobe |
| lad_o | output | 4 | Address/data nibble driven by the host |
| lad_oe | output | 1 | Host drive enable for the nibble bus |
| lad_i | input | 4 | Nibble bus as seen from the pins |

## Verification
The bench builds the block with its defaults: 16-bit ports, 4-entry FIFOs, a 3-bit count field clamped at four cycles, and a 256-clock wait limit. These values keep both sides of the wait boundary (256 accepted, 257 aborted) cheap to run. They also let a five-byte load overflow the write FIFO, a count of 7 exercise the clamp, and a start at 0xFFFE show the address wrap. A pin-level peripheral model inserts alternating wait codes, returns address-derived read data and records every address and data nibble. Each burst is thus checked against values computed from the requirements.

// File: rtl/lpc_host_pkg.sv
// Shared definitions for the LPC I/O burst host.
// Assumes an 8-bit register byte offset and 4-bit nibble bus.
package lpc_host_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_CTYPE, S_ADDR, S_WDATA, S_TAR1, S_TAR2,
        S_SYNC, S_RDATA, S_TARE1, S_TARE2, S_ABORT
    } seq_state_t;

    // register byte offsets (software decodes these)
    localparam logic [7:0] OFF_GO    = 8'h00;
    localparam logic [7:0] OFF_STAT  = 8'h04;
    localparam logic [7:0] OFF_COUNT = 8'h10;
    localparam logic [7:0] OFF_CMD   = 8'h14;
    localparam logic [7:0] OFF_PORT  = 8'h20;
    localparam logic [7:0] OFF_WBUF  = 8'h24;
    localparam logic [7:0] OFF_RBUF  = 8'h28;

    // nibble codes on the bus
    localparam logic [3:0] NIB_START   = 4'h0;
    localparam logic [3:0] NIB_IO_RD   = 4'h0;
    localparam logic [3:0] NIB_IO_WR   = 4'h2;
    localparam logic [3:0] NIB_IDLE    = 4'hF;
    localparam logic [3:0] SYNC_READY  = 4'h0;
    localparam logic [3:0] SYNC_WAIT_S = 4'h5;
    localparam logic [3:0] SYNC_WAIT_L = 4'h6;

endpackage

// File: rtl/lpc_byte_fifo.sv
// Small byte FIFO with synchronous clear.
// Pushes into a full FIFO and pops from an empty one are dropped; the
// head reads 0xFF while empty. Clear wins over push and pop.
module lpc_byte_fifo #(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       push,
    input  logic [7:0] din,
    input  logic       pop,
    output logic [7:0] dout,
    output logic       empty,
    output logic       full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = empty ? 8'hFF : mem[rp];

    // storage write
    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wp] <= din;
    end

    // pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH))
        else $error("fifo occupancy beyond depth");

endmodule

// File: rtl/lpc_cycle_seq.sv
// Sequencer that runs a burst of byte-wide LPC I/O cycles on the pins.
// Assumes the bus clock equals clk and that the caller holds wbyte at
// the write-FIFO head; pops/pushes are single-cycle strobes.
module lpc_cycle_seq
    import lpc_host_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 3,
    parameter int MAX_WAIT   = 256,
    parameter int ABORT_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_write,
    input  logic              same_port,
    input  logic [CNT_W-1:0]  n_cycles,
    input  logic [ADDR_W-1:0] base_port,
    input  logic [7:0]        wbyte,
    output logic              wpop,
    output logic              rpush,
    output logic [7:0]        rbyte,
    output logic              busy,
    output logic              done_ok,
    output logic              aborted,
    output logic              lframe_n,
    output logic [3:0]        lad_o,
    output logic              lad_oe,
    input  logic [3:0]        lad_i
);
    localparam int NIB  = ADDR_W / 4;
    localparam int NW   = (NIB > 1) ? $clog2(NIB) : 1;
    localparam int WW   = $clog2(MAX_WAIT + 1);
    localparam int AW   = (ABORT_CLKS > 1) ? $clog2(ABORT_CLKS) : 1;

    seq_state_t        state;
    logic [NW-1:0]     nib;
    logic [CNT_W-1:0]  idx, cnt_l;
    logic [WW-1:0]     wait_cnt;
    logic [AW-1:0]     acnt;
    logic [3:0]        rlo;
    logic              wr_l, same_l, last;
    logic [ADDR_W-1:0] base_l, cur_port;

    assign cur_port = same_l ? base_l : base_l + ADDR_W'(idx);
    assign last     = (idx == cnt_l - 1'b1);
    assign busy     = (state != S_IDLE);
    assign done_ok  = (state == S_TARE2) && last;
    assign aborted  = (state == S_ABORT) && (acnt == AW'(ABORT_CLKS - 1));
    assign rbyte    = {lad_i, rlo};

    // pin drive and FIFO strobes decoded from the phase
    always_comb begin
        lframe_n = 1'b1;
        lad_oe   = 1'b0;
        lad_o    = NIB_IDLE;
        wpop     = 1'b0;
        rpush    = 1'b0;
        case (state)
            S_START: begin lframe_n = 1'b0; lad_oe = 1'b1; lad_o = NIB_START; end
            S_CTYPE: begin lad_oe = 1'b1; lad_o = wr_l ? NIB_IO_WR : NIB_IO_RD; end
            S_ADDR:  begin
                lad_oe = 1'b1;
                lad_o  = cur_port[(NIB - 1 - int'(nib)) * 4 +: 4];
            end
            S_WDATA: begin
                lad_oe = 1'b1;
                lad_o  = nib[0] ? wbyte[7:4] : wbyte[3:0];
                wpop   = nib[0];
            end
            S_TAR1:  begin lad_oe = 1'b1; lad_o = NIB_IDLE; end
            S_RDATA: rpush = nib[0];
            S_ABORT: begin lframe_n = 1'b0; lad_oe = 1'b1; lad_o = NIB_IDLE; end
            default: ;
        endcase
    end

    // phase sequencing, burst bookkeeping and sync handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            nib      <= '0;
            idx      <= '0;
            cnt_l    <= '0;
            wait_cnt <= '0;
            acnt     <= '0;
            rlo      <= '0;
            wr_l     <= 1'b0;
            same_l   <= 1'b0;
            base_l   <= '0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    wr_l   <= is_write;
                    same_l <= same_port;
                    cnt_l  <= n_cycles;
                    base_l <= base_port;
                    idx    <= '0;
                    state  <= S_START;
                end
                S_START: state <= S_CTYPE;
                S_CTYPE: begin nib <= '0; state <= S_ADDR; end
                S_ADDR: begin
                    if (nib == NW'(NIB - 1)) begin
                        nib   <= '0;
                        state <= wr_l ? S_WDATA : S_TAR1;
                    end else begin
                        nib <= nib + 1'b1;
                    end
                end
                S_WDATA: begin
                    nib <= nib[0] ? '0 : NW'(1);
                    if (nib[0]) state <= S_TAR1;
                end
                S_TAR1: state <= S_TAR2;
                S_TAR2: begin wait_cnt <= '0; state <= S_SYNC; end
                S_SYNC: begin
                    if (lad_i == SYNC_READY) begin
                        nib   <= '0;
                        state <= wr_l ? S_TARE1 : S_RDATA;
                    end else if (lad_i == SYNC_WAIT_S || lad_i == SYNC_WAIT_L) begin
                        if (wait_cnt == WW'(MAX_WAIT)) begin
                            acnt  <= '0;
                            state <= S_ABORT;
                        end else begin
                            wait_cnt <= wait_cnt + 1'b1;
                        end
                    end else begin
                        acnt  <= '0;
                        state <= S_ABORT;
                    end
                end
                S_RDATA: begin
                    if (nib[0]) begin
                        nib   <= '0;
                        state <= S_TARE1;
                    end else begin
                        rlo <= lad_i;
                        nib <= NW'(1);
                    end
                end
                S_TARE1: state <= S_TARE2;
                S_TARE2: begin
                    if (last) state <= S_IDLE;
                    else begin
                        idx   <= idx + 1'b1;
                        state <= S_START;
                    end
                end
                S_ABORT: begin
                    if (acnt == AW'(ABORT_CLKS - 1)) state <= S_IDLE;
                    else acnt <= acnt + 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    p_start_one_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!lframe_n && lad_oe && lad_o == NIB_START) |=> lframe_n)
        else $error("start strobe longer than one clock");

    p_wait_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt <= WW'(MAX_WAIT))
        else $error("wait counter past limit");

    p_bad_sync_aborts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SYNC && lad_i != SYNC_READY && lad_i != SYNC_WAIT_S &&
         lad_i != SYNC_WAIT_L) |=> (!lframe_n && lad_o == NIB_IDLE))
        else $error("error sync not followed by abort pattern");

    p_abort_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ABORT && acnt != AW'(ABORT_CLKS - 1)) |=>
        (!lframe_n && lad_oe && lad_o == NIB_IDLE))
        else $error("abort pattern cut short");

endmodule

// File: rtl/lpc_burst_host.sv
// Register-mapped LPC I/O burst host: register file, byte FIFOs and
// the cycle sequencer. Assumes one register access per clock and that
// read data is taken in the same cycle as the read strobe.
module lpc_burst_host
    import lpc_host_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 3,
    parameter int MAX_CYC    = 4,
    parameter int FIFO_DEPTH = 4,
    parameter int MAX_WAIT   = 256,
    parameter int ABORT_CLKS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wen,
    input  logic [31:0] bus_wdata,
    input  logic        bus_ren,
    output logic [31:0] bus_rdata,
    output logic        lframe_n,
    output logic [3:0]  lad_o,
    output logic        lad_oe,
    input  logic [3:0]  lad_i
);
    logic [CNT_W-1:0]  cnt_r, cnt_eff;
    logic              cmd_wr, cmd_same;
    logic [ADDR_W-1:0] port_r;
    logic              finished;
    logic              busy, done_ok, aborted;
    logic              go_acc, cfg_we;
    logic              wpop, rpush, rpop, wpush;
    logic [7:0]        wbyte, rbyte, rhead;
    logic              w_empty, w_full, r_empty, r_full;
    logic              unused_bits;

    assign unused_bits = ^{bus_wdata[31:ADDR_W], bus_wdata[2:1],
                           w_empty, w_full, r_empty, r_full};

    assign cfg_we  = bus_wen && !busy;
    assign cnt_eff = (cnt_r > CNT_W'(MAX_CYC)) ? CNT_W'(MAX_CYC) : cnt_r;
    assign go_acc  = cfg_we && (bus_addr == OFF_GO) && bus_wdata[0];
    assign wpush   = cfg_we && (bus_addr == OFF_WBUF);
    assign rpop    = bus_ren && (bus_addr == OFF_RBUF);

    // configuration registers, writable only between bursts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_r    <= '0;
            cmd_wr   <= 1'b0;
            cmd_same <= 1'b0;
            port_r   <= '0;
        end else if (cfg_we) begin
            case (bus_addr)
                OFF_COUNT: cnt_r <= bus_wdata[CNT_W-1:0];
                OFF_CMD:   begin cmd_wr <= bus_wdata[0]; cmd_same <= bus_wdata[3]; end
                OFF_PORT:  port_r <= bus_wdata[ADDR_W-1:0];
                default: ;
            endcase
        end
    end

    // completion flag: cleared by a start, set by a clean finish
    always_ff @(posedge clk) begin
        if (!rst_n)       finished <= 1'b0;
        else if (go_acc)  finished <= (cnt_eff == '0);
        else if (done_ok) finished <= 1'b1;
    end

    // register read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_STAT:  bus_rdata = {30'd0, finished, !busy};
            OFF_COUNT: bus_rdata = 32'(cnt_r);
            OFF_CMD:   bus_rdata = {28'd0, cmd_same, 2'b00, cmd_wr};
            OFF_PORT:  bus_rdata = 32'(port_r);
            OFF_RBUF:  bus_rdata = {24'd0, rhead};
            default:   bus_rdata = '0;
        endcase
    end

    lpc_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_wbuf (
        .clk(clk), .rst_n(rst_n), .clr(done_ok || aborted),
        .push(wpush), .din(bus_wdata[7:0]), .pop(wpop),
        .dout(wbyte), .empty(w_empty), .full(w_full)
    );

    lpc_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_rbuf (
        .clk(clk), .rst_n(rst_n), .clr(go_acc),
        .push(rpush), .din(rbyte), .pop(rpop),
        .dout(rhead), .empty(r_empty), .full(r_full)
    );

    lpc_cycle_seq #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .MAX_WAIT(MAX_WAIT), .ABORT_CLKS(ABORT_CLKS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(go_acc && (cnt_eff != '0)),
        .is_write(cmd_wr), .same_port(cmd_same),
        .n_cycles(cnt_eff), .base_port(port_r), .wbyte(wbyte),
        .wpop(wpop), .rpush(rpush), .rbyte(rbyte),
        .busy(busy), .done_ok(done_ok), .aborted(aborted),
        .lframe_n(lframe_n), .lad_o(lad_o), .lad_oe(lad_oe), .lad_i(lad_i)
    );

    p_busy_after_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (go_acc && cnt_eff != '0) |=> busy)
        else $error("accepted start did not raise busy");

    p_zero_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (go_acc && cnt_eff == '0) |=> (finished && !busy))
        else $error("zero-length burst not finished at once");

    p_cfg_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wen) |=> ($stable(cnt_r) && $stable(port_r) && $stable(cmd_wr)))
        else $error("configuration changed during burst");

    p_abort_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        aborted |=> (!finished && !busy))
        else $error("abort left finished set");

endmodule

// File: tb/test_lpc_burst_host.sv
module test_lpc_burst_host;
    import lpc_host_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ren = 1'b0;
    logic [31:0] bus_rdata;
    logic        lframe_n, lad_oe;
    logic [3:0]  lad_o, lad_i;

    always #5 clk = ~clk;

    lpc_burst_host i_lpc_burst_host (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_ren(bus_ren), .bus_rdata(bus_rdata),
        .lframe_n(lframe_n), .lad_o(lad_o), .lad_oe(lad_oe), .lad_i(lad_i)
    );

    int nchk = 0, nfail = 0;
    bit done_flag = 0;

    // peripheral model state
    int         pos = -1;
    bit         pwr = 0;
    logic [15:0] paddr = '0;
    logic [3:0] wlo = '0;
    logic [7:0] cur_rb = '0;
    int         nseen = 0;
    logic [15:0] seen_addr [8];
    logic [7:0]  seen_wd [8];
    logic [3:0]  seen_ct [8];
    int         cfg_waits = 0;
    logic [3:0] cfg_code = 4'h0;
    int         abort_run = 0, abort_max = 0;

    function automatic logic [7:0] rdfn(logic [15:0] a, int i);
        return a[7:0] ^ 8'h3C ^ (8'(i) << 4);
    endfunction

    // observe pins away from the active edge
    always @(negedge clk) begin
        if (!lframe_n && lad_oe && lad_o == 4'h0) pos = 0;
        else if (pos >= 0) pos = pos + 1;
        if (!lframe_n && lad_oe && lad_o == 4'hF) begin
            pos = -1;
            abort_run = abort_run + 1;
            if (abort_run > abort_max) abort_max = abort_run;
        end else abort_run = 0;
        if (pos == 1) begin
            pwr = (lad_o == 4'h2);
            if (nseen < 8) seen_ct[nseen] = lad_o;
        end
        if (pos >= 2 && pos <= 5) paddr = {paddr[11:0], lad_o};
        if (pos == 5) begin
            cur_rb = rdfn(paddr, nseen);
            if (nseen < 8) seen_addr[nseen] = paddr;
            nseen = nseen + 1;
        end
        if (pwr && pos == 6) wlo = lad_o;
        if (pwr && pos == 7 && nseen <= 8) seen_wd[nseen-1] = {lad_o, wlo};
    end

    // peripheral responses: waits, sync code, read data
    always_comb begin
        int sp;
        lad_i = 4'hF;
        sp = pwr ? 10 : 8;
        if (pos >= 0) begin
            if (pos >= sp && pos < sp + cfg_waits)
                lad_i = ((pos - sp) % 2 == 1) ? 4'h6 : 4'h5;
            else if (pos == sp + cfg_waits) lad_i = cfg_code;
            else if (!pwr && cfg_code == 4'h0 && pos == sp + cfg_waits + 1) lad_i = cur_rb[3:0];
            else if (!pwr && cfg_code == 4'h0 && pos == sp + cfg_waits + 2) lad_i = cur_rb[7:4];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(posedge clk);
        #1 bus_wen = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_ren = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_ren = 1'b0;
    endtask

    task automatic wait_idle(output int busy_n);
        logic [31:0] d;
        busy_n = 0;
        forever begin
            reg_rd(OFF_STAT, d);
            if (d[0]) break;
            busy_n++;
            if (busy_n > 6000) break;
        end
    endtask

    task automatic setup(input bit wr, input bit same, input int cnt, input logic [15:0] a,
                         input int waits, input logic [3:0] code);
        nseen = 0; abort_max = 0; cfg_waits = waits; cfg_code = code;
        reg_wr(OFF_COUNT, 32'(cnt));
        reg_wr(OFF_CMD, {28'd0, same, 2'b00, wr});
        reg_wr(OFF_PORT, 32'(a));
    endtask

    typedef struct packed {
        logic        wr;
        logic        same;
        logic [2:0]  cnt;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic [8:0]  waits;
        logic [3:0]  code;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 3'd1, 16'h00E4, 32'h0,        9'd0,   4'h0},
        '{1'b1, 1'b0, 3'd4, 16'h0378, 32'hA1B2C3D4, 9'd0,   4'h0},
        '{1'b0, 1'b1, 3'd4, 16'h02F8, 32'h0,        9'd3,   4'h0},
        '{1'b1, 1'b1, 3'd2, 16'h0080, 32'h00005A3C, 9'd2,   4'h0},
        '{1'b0, 1'b0, 3'd3, 16'hFFFE, 32'h0,        9'd0,   4'h0},
        '{1'b0, 1'b0, 3'd7, 16'h0010, 32'h0,        9'd1,   4'h0},
        '{1'b1, 1'b0, 3'd1, 16'h1234, 32'h00000077, 9'd256, 4'h0},
        '{1'b0, 1'b0, 3'd2, 16'h0060, 32'h0,        9'd257, 4'h0},
        '{1'b1, 1'b0, 3'd3, 16'h0400, 32'h00332211, 9'd0,   4'hA},
        '{1'b0, 1'b0, 3'd1, 16'h0070, 32'h0,        9'd0,   4'h9}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int bn;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        reg_rd(OFF_STAT, d);  chk("R1 status after reset", d, 32'h1);
        reg_rd(OFF_CMD, d);   chk("R1 command after reset", d, 32'h0);
        reg_rd(OFF_COUNT, d); chk("R1 count after reset", d, 32'h0);
        chk("R1 frame high", 32'(lframe_n), 32'h1);
        chk("R1 bus released", 32'(lad_oe), 32'h0);
        reg_rd(OFF_RBUF, d);  chk("R7 empty read fifo", d, 32'hFF);

        // table-driven bursts
        for (int v = 0; v < NVEC; v++) begin
            vec_t t;
            int n;
            bit ok;
            t  = VECS[v];
            n  = (t.cnt > 4) ? 4 : int'(t.cnt);
            ok = (t.code == 4'h0) && (t.waits <= 256);
            setup(t.wr, t.same, int'(t.cnt), t.addr, int'(t.waits), t.code);
            if (t.wr) for (int b = 0; b < n; b++) reg_wr(OFF_WBUF, 32'(t.wdata[8*b +: 8]));
            reg_wr(OFF_GO, 32'h1);
            wait_idle(bn);
            reg_rd(OFF_STAT, d);
            if (ok) begin
                chk("R9 status after clean burst", d, 32'h3);
                chk("R11 busy clocks", 32'(bn), 32'(n * (13 + int'(t.waits))));
                chk("R2 cycle count", 32'(nseen), 32'(n));
                for (int i = 0; i < n; i++) begin
                    logic [15:0] ea;
                    ea = t.same ? t.addr : t.addr + 16'(i);
                    chk("R3 cycle type nibble", 32'(seen_ct[i]), t.wr ? 32'h2 : 32'h0);
                    chk("R4 port of cycle", 32'(seen_addr[i]), 32'(ea));
                    if (t.wr) chk("R5 write byte", 32'(seen_wd[i]), 32'(t.wdata[8*i +: 8]));
                    else begin
                        reg_rd(OFF_RBUF, d);
                        chk("R7 read byte order", d, 32'(rdfn(ea, i)));
                    end
                end
                if (!t.wr) begin
                    reg_rd(OFF_RBUF, d);
                    chk("R7 drained fifo", d, 32'hFF);
                end
            end else begin
                chk("R8 status after abort", d, 32'h1);
                chk("R8 abort pattern length", 32'(abort_max >= 4), 32'h1);
                chk("R8 frame released", 32'(lframe_n), 32'h1);
            end
        end

        // R2 idle drops on the clock after start; zero count
        setup(1'b0, 1'b0, 1, 16'h0200, 0, 4'h0);
        reg_wr(OFF_GO, 32'h1);
        reg_rd(OFF_STAT, d); chk("R2 idle drops after start", d, 32'h0);
        wait_idle(bn);
        setup(1'b0, 1'b0, 0, 16'h0200, 0, 4'h0);
        reg_wr(OFF_GO, 32'h1);
        reg_rd(OFF_STAT, d); chk("R2 zero count completes", d, 32'h3);
        repeat (20) @(posedge clk);
        chk("R2 zero count no frame", 32'(nseen), 32'h0);

        // R10 writes during a burst are ignored
        setup(1'b0, 1'b0, 1, 16'h0100, 20, 4'h0);
        reg_wr(OFF_GO, 32'h1);
        reg_wr(OFF_GO, 32'h1);
        reg_wr(OFF_PORT, 32'h1111);
        reg_wr(OFF_COUNT, 32'h4);
        reg_wr(OFF_WBUF, 32'h99);
        wait_idle(bn);
        repeat (30) @(posedge clk);
        chk("R10 single burst ran", 32'(nseen), 32'h1);
        chk("R10 port unchanged on pins", 32'(seen_addr[0]), 32'h0100);
        reg_rd(OFF_PORT, d);  chk("R10 port register held", d, 32'h0100);
        reg_rd(OFF_COUNT, d); chk("R10 count register held", d, 32'h1);
        reg_rd(OFF_RBUF, d);  chk("R7 byte after ignored writes", d, 32'(rdfn(16'h0100, 0)));

        // R5 leftover bytes flushed, empty supplies 0xFF, overflow dropped
        setup(1'b1, 1'b0, 1, 16'h0300, 0, 4'h0);
        reg_wr(OFF_WBUF, 32'h11); reg_wr(OFF_WBUF, 32'h22); reg_wr(OFF_WBUF, 32'h33);
        reg_wr(OFF_GO, 32'h1); wait_idle(bn);
        chk("R5 first byte sent", 32'(seen_wd[0]), 32'h11);
        setup(1'b1, 1'b0, 1, 16'h0300, 0, 4'h0);
        reg_wr(OFF_GO, 32'h1); wait_idle(bn);
        chk("R5 leftovers flushed", 32'(seen_wd[0]), 32'hFF);
        setup(1'b1, 1'b1, 4, 16'h0300, 0, 4'h0);
        for (int b = 1; b <= 5; b++) reg_wr(OFF_WBUF, 32'(b));
        reg_wr(OFF_GO, 32'h1); wait_idle(bn);
        chk("R5 fourth byte kept", 32'(seen_wd[3]), 32'h4);
        chk("R5 overflow dropped", 32'(seen_wd[0]), 32'h1);

        // R7 read fifo emptied by a new start
        setup(1'b0, 1'b0, 2, 16'h0040, 0, 4'h0);
        reg_wr(OFF_GO, 32'h1); wait_idle(bn);
        setup(1'b0, 1'b0, 1, 16'h0050, 0, 4'h0);
        reg_wr(OFF_GO, 32'h1); wait_idle(bn);
        reg_rd(OFF_RBUF, d); chk("R7 stale bytes cleared", d, 32'(rdfn(16'h0050, 0)));
        reg_rd(OFF_RBUF, d); chk("R7 empty after new burst", d, 32'hFF);

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule